// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the physical-layer side of a single-wire request line driven by the link controller. The line is sampled once per system clock and rests low. A high sample starts a frame, and the block then shifts in a 3-bit kind field. The kind field sets the frame length: bus requests carry a speed field, register reads carry an address, and register writes carry an address and a data byte. The final bit must be low. When a frame completes cleanly, the block emits a one-cycle pulse with the decoded fields. A malformed frame produces a one-cycle error pulse instead.

Arbitration-class requests (immediate, isochronous, priority, fair) are also held in a pending register for the arbiter. Priority and fair requests yield to packet reception from the cable. Such a request is discarded if the receive indication is seen during its frame. It is also cleared from the pending register when reception begins later. A pending isochronous request is cleared when the link sends a register access, or when the arbiter reports completion.

Top module: `sreq_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `dec_valid`, `frame_err` and `pend_valid`. It also returns the decoder to hunting for a start bit, so a partly received frame is abandoned. While the line stays low, no output pulse occurs.
- R2: A bus request is 7 bits on the wire: a high start bit, then the kind MSB first, then the 2-bit speed MSB first (00 = 100 Mbit/s, 01 = 200 Mbit/s), then a low stop bit. Kind codes are 000 immediate, 001 isochronous, 010 priority and 011 fair. `dec_valid` is high for exactly the one cycle after the edge that samples the stop bit, with `dec_kind` and `dec_speed` set.
- R3: A register read is 9 bits: start, kind 100, a 4-bit address MSB first, and stop. The pulse carries `dec_kind`=100 and `dec_addr`.
- R4: A register write is 17 bits: start, kind 101, a 4-bit address, an 8-bit data byte (each MSB first), and stop. The pulse carries `dec_addr` and `dec_data`.
- R5: A high sample where the stop bit is due gives a one-cycle `frame_err` pulse in the cycle after that edge, and no `dec_valid`. The decoder then ignores the line until it samples low, and only after that accepts a new start bit.
- R6: Kind codes 110 and 111 are reserved. After the edge that samples the frame bit following the kind field, they give a one-cycle `frame_err` pulse and no `dec_valid`. Recovery then follows R5.
- R7: A priority or fair request is dropped when `rx_active` is sampled high on any edge from its start bit to its stop bit. It produces no pulse, no error and no pending entry. Immediate and isochronous requests are not dropped for this reason.
- R8: While a priority or fair request is pending, an edge that samples `rx_active` high clears `pend_valid`. Pending immediate and isochronous requests are kept.
- R9: An accepted read or write clears a pending isochronous request. An edge that samples `arb_done` high clears any pending request, unless a bus request completes on that same edge.
- R10: An accepted bus request loads `pend_valid`, `pend_kind` and `pend_speed` in the same cycle as its `dec_valid` pulse. It replaces any earlier pending request.
- R11: A new start bit sampled on the edge right after a stop bit begins a new frame. Back-to-back frames are each decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 1 | Serial request line from the link, idles low |
| rx_active | input | 1 | High while the PHY is presenting a received packet |
| arb_done | input | 1 | One-cycle pulse from the arbiter: pending request served or finished |
| dec_valid | output | 1 | One-cycle pulse: a request was decoded |
| dec_kind | output | 3 | Decoded kind code |
| dec_speed | output | SPD_W | Speed field of a bus request, zero otherwise |
| dec_addr | output | ADDR_W | Register address of a read or write, zero otherwise |
| dec_data | output | DATA_W | Data byte of a write, zero otherwise |
| frame_err | output | 1 | One-cycle pulse: bad stop bit or reserved kind |
| pend_valid | output | 1 | An arbitration request is pending |
| pend_kind | output | 3 | Kind of the pending request |
| pend_speed | output | SPD_W | Speed of the pending request |

## Verification
The assertions assume the link holds the request line at one value for a full clock period. They also assume `arb_done` is only raised as a single-cycle pulse. The bench changes every input only on the falling clock edge and holds it until the next falling edge. It raises `rx_active` and `arb_done` for exactly one cycle, at bit positions it chooses, so that each drop and clear rule is hit at a known edge. After every malformed frame, the bench returns the line low before sending the next start bit, as the recovery rule requires.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_IMM  = 3'd0,
        K_ISO  = 3'd1,
        K_PRIO = 3'd2,
        K_FAIR = 3'd3,
        K_RD   = 3'd4,
        K_WR   = 3'd5,
        K_RSV6 = 3'd6,
        K_RSV7 = 3'd7
    } req_kind_e;

    function automatic logic kind_reserved(input req_kind_e k);
        return (k == K_RSV6) || (k == K_RSV7);
    endfunction

    function automatic logic kind_yields(input req_kind_e k);
        return (k == K_PRIO) || (k == K_FAIR);
    endfunction

    function automatic logic kind_is_bus(input req_kind_e k);
        return (k == K_IMM) || (k == K_ISO) || (k == K_PRIO) || (k == K_FAIR);
    endfunction

endpackage

// File: rtl/sreq_shifter.sv
module sreq_shifter
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SPD_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              rx_in,
    output logic              acc_ok,
    output req_kind_e         acc_kind,
    output logic [SPD_W-1:0]  acc_spd,
    output logic              out_ok,
    output logic              out_err,
    output req_kind_e         out_kind,
    output logic [SPD_W-1:0]  out_spd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int BUS_LEN = KIND_W + SPD_W;
    localparam int RD_LEN  = KIND_W + ADDR_W;
    localparam int WR_LEN  = RD_LEN + DATA_W;
    localparam int SH_W    = WR_LEN;
    localparam int CNT_W   = $clog2(WR_LEN + 1);

    typedef enum logic [1:0] {HUNT = 2'd0, BODY = 2'd1, DRAIN = 2'd2} phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [SH_W-1:0]    sh;
        logic [CNT_W-1:0]   cnt;
        logic               rx_seen;
        req_kind_e          kind;
        logic               ok;
        logic               err;
        req_kind_e          o_kind;
        logic [SPD_W-1:0]   o_spd;
        logic [ADDR_W-1:0]  o_addr;
        logic [DATA_W-1:0]  o_data;
    } st_t;

    st_t              st_q, st_d;
    logic [CNT_W-1:0] need;
    logic             stop_now;
    logic             drop;
    req_kind_e        kind_in_sh;

    always_comb begin
        st_d       = st_q;
        st_d.ok    = 1'b0;
        st_d.err   = 1'b0;
        acc_ok     = 1'b0;
        kind_in_sh = req_kind_e'(st_q.sh[KIND_W-1:0]);
        // payload length follows the kind captured after the first three bits
        if (st_q.kind == K_RD)      need = CNT_W'(RD_LEN);
        else if (st_q.kind == K_WR) need = CNT_W'(WR_LEN);
        else                        need = CNT_W'(BUS_LEN);
        stop_now = (st_q.cnt > CNT_W'(KIND_W)) && (st_q.cnt == need);
        drop     = kind_yields(st_q.kind) && (st_q.rx_seen || rx_in);

        unique case (st_q.phase)
            HUNT: begin
                if (line_in) begin
                    st_d.phase   = BODY;
                    st_d.sh      = '0;
                    st_d.cnt     = '0;
                    st_d.rx_seen = rx_in;
                end
            end
            BODY: begin
                st_d.rx_seen = st_q.rx_seen || rx_in;
                if ((st_q.cnt == CNT_W'(KIND_W)) && kind_reserved(kind_in_sh)) begin
                    st_d.err   = 1'b1;
                    st_d.phase = DRAIN;
                end else if (stop_now) begin
                    if (line_in) begin
                        st_d.err   = 1'b1;
                        st_d.phase = DRAIN;
                    end else begin
                        st_d.phase = HUNT;
                        if (!drop) begin
                            acc_ok      = 1'b1;
                            st_d.ok     = 1'b1;
                            st_d.o_kind = st_q.kind;
                            st_d.o_spd  = '0;
                            st_d.o_addr = '0;
                            st_d.o_data = '0;
                            if (st_q.kind == K_RD) begin
                                st_d.o_addr = st_q.sh[ADDR_W-1:0];
                            end else if (st_q.kind == K_WR) begin
                                st_d.o_addr = st_q.sh[DATA_W +: ADDR_W];
                                st_d.o_data = st_q.sh[DATA_W-1:0];
                            end else begin
                                st_d.o_spd  = st_q.sh[SPD_W-1:0];
                            end
                        end
                    end
                end else begin
                    st_d.sh  = {st_q.sh[SH_W-2:0], line_in};
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(KIND_W)) st_d.kind = kind_in_sh;
                end
            end
            DRAIN: begin
                if (!line_in) st_d.phase = HUNT;
            end
            default: st_d.phase = HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_kind = st_q.kind;
    assign acc_spd  = st_q.sh[SPD_W-1:0];
    assign out_ok   = st_q.ok;
    assign out_err  = st_q.err;
    assign out_kind = st_q.o_kind;
    assign out_spd  = st_q.o_spd;
    assign out_addr = st_q.o_addr;
    assign out_data = st_q.o_data;

endmodule

// File: rtl/sreq_pend.sv
module sreq_pend
    import sreq_pkg::*;
#(
    parameter int SPD_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic             done_in,
    input  logic             acc_ok,
    input  req_kind_e        acc_kind,
    input  logic [SPD_W-1:0] acc_spd,
    output logic             pend_v,
    output req_kind_e        pend_k,
    output logic [SPD_W-1:0] pend_s
);

    typedef struct packed {
        logic             v;
        req_kind_e        k;
        logic [SPD_W-1:0] s;
    } pend_t;

    pend_t pq_q, pq_d;

    always_comb begin
        pq_d = pq_q;
        if (acc_ok && kind_is_bus(acc_kind)) begin
            pq_d.v = 1'b1;
            pq_d.k = acc_kind;
            pq_d.s = acc_spd;
        end else if (done_in) begin
            pq_d.v = 1'b0;
        end else if (pq_q.v && kind_yields(pq_q.k) && rx_in) begin
            pq_d.v = 1'b0;
        end else if (acc_ok && (pq_q.k == K_ISO)) begin
            pq_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pq_q <= '0;
        else     pq_q <= pq_d;
    end

    assign pend_v = pq_q.v;
    assign pend_k = pq_q.k;
    assign pend_s = pq_q.s;

endmodule

// File: rtl/sreq_decoder.sv
module sreq_decoder
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SPD_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              rx_active,
    input  logic              arb_done,
    output logic              dec_valid,
    output logic [2:0]        dec_kind,
    output logic [SPD_W-1:0]  dec_speed,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [DATA_W-1:0] dec_data,
    output logic              frame_err,
    output logic              pend_valid,
    output logic [2:0]        pend_kind,
    output logic [SPD_W-1:0]  pend_speed
);

    logic             acc_ok;
    req_kind_e        acc_kind;
    logic [SPD_W-1:0] acc_spd;
    req_kind_e        out_kind;
    req_kind_e        pk;

    sreq_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .line_in  (req_in),
        .rx_in    (rx_active),
        .acc_ok   (acc_ok),
        .acc_kind (acc_kind),
        .acc_spd  (acc_spd),
        .out_ok   (dec_valid),
        .out_err  (frame_err),
        .out_kind (out_kind),
        .out_spd  (dec_speed),
        .out_addr (dec_addr),
        .out_data (dec_data)
    );

    sreq_pend #(.SPD_W(SPD_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .rx_in    (rx_active),
        .done_in  (arb_done),
        .acc_ok   (acc_ok),
        .acc_kind (acc_kind),
        .acc_spd  (acc_spd),
        .pend_v   (pend_valid),
        .pend_k   (pk),
        .pend_s   (pend_speed)
    );

    assign dec_kind  = out_kind;
    assign pend_kind = pk;

endmodule

// File: rtl/sreq_decoder_chk.sv
module sreq_decoder_chk #(
    parameter int SPD_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_in,
    input logic             rx_active,
    input logic             arb_done,
    input logic             dec_valid,
    input logic [2:0]       dec_kind,
    input logic [SPD_W-1:0] dec_speed,
    input logic             frame_err,
    input logic             pend_valid,
    input logic [2:0]       pend_kind,
    input logic [SPD_W-1:0] pend_speed
);

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(!req_in));

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !dec_valid);

    // R6
    no_reserved_out_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> !(dec_kind[2] && dec_kind[1]));

    // R8
    rx_clears_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !pend_kind[2] && pend_kind[1] && rx_active)
        |=> (!pend_valid || !pend_kind[1]));

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        arb_done |=> (!pend_valid || (dec_valid && !dec_kind[2])));

    // R10
    load_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_kind[2])
        |-> (pend_valid && pend_kind == dec_kind && pend_speed == dec_speed));

endmodule

bind sreq_decoder sreq_decoder_chk #(.SPD_W(SPD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_in     (req_in),
    .rx_active  (rx_active),
    .arb_done   (arb_done),
    .dec_valid  (dec_valid),
    .dec_kind   (dec_kind),
    .dec_speed  (dec_speed),
    .frame_err  (frame_err),
    .pend_valid (pend_valid),
    .pend_kind  (pend_kind),
    .pend_speed (pend_speed)
);

// File: tb/sreq_decoder_test.sv
module sreq_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_in = 1'b0;
    logic       rx_active = 1'b0;
    logic       arb_done = 1'b0;
    logic       dec_valid;
    logic [2:0] dec_kind;
    logic [1:0] dec_speed;
    logic [3:0] dec_addr;
    logic [7:0] dec_data;
    logic       frame_err;
    logic       pend_valid;
    logic [2:0] pend_kind;
    logic [1:0] pend_speed;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    sreq_decoder uut (
        .clk(clk), .rst(rst), .req_in(req_in), .rx_active(rx_active),
        .arb_done(arb_done), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_speed(dec_speed), .dec_addr(dec_addr), .dec_data(dec_data),
        .frame_err(frame_err), .pend_valid(pend_valid), .pend_kind(pend_kind),
        .pend_speed(pend_speed)
    );

    typedef struct {
        bit         err;
        logic [2:0] kind;
        logic [1:0] spd;
        logic [3:0] addr;
        logic [7:0] data;
        string      tag;
    } item_t;

    item_t exp_q[$];
    item_t e;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_ok(input logic [2:0] k, input logic [1:0] s,
                           input logic [3:0] a, input logic [7:0] d, input string tag);
        item_t it;
        it.err = 1'b0; it.kind = k; it.spd = s; it.addr = a; it.data = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_err(input string tag);
        item_t it;
        it.err = 1'b1; it.kind = '0; it.spd = '0; it.addr = '0; it.data = '0; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // drive len bits MSB-first from v[39]; rx_active high during bit rx_at
    task automatic drive(input logic [39:0] v, input int len, input int rx_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            req_in    = v[39-i];
            rx_active = (i == rx_at);
        end
        @(negedge clk);
        rx_active = 1'b0;
    endtask

    task automatic bus_req(input logic [2:0] k, input logic [1:0] s,
                           input int rx_at, input bit dropped, input string tag);
        if (!dropped) push_ok(k, s, 4'd0, 8'd0, tag);
        drive(40'({1'b1, k, s, 1'b0}) << 33, 7, rx_at);
        check(dec_valid == !dropped, tag, "valid one cycle after stop",
              int'(dec_valid), int'(!dropped));
    endtask

    task automatic rd_req(input logic [3:0] a, input string tag);
        push_ok(3'b100, 2'd0, a, 8'd0, tag);
        drive(40'({1'b1, 3'b100, a, 1'b0}) << 31, 9, -1);
    endtask

    task automatic wr_req(input logic [3:0] a, input logic [7:0] d, input string tag);
        push_ok(3'b101, 2'd0, a, d, tag);
        drive(40'({1'b1, 3'b101, a, d, 1'b0}) << 23, 17, -1);
    endtask

    task automatic chk_pend(input bit v, input logic [2:0] k, input string tag);
        check(pend_valid == v, tag, "pend_valid", int'(pend_valid), int'(v));
        if (v) check(pend_kind == k, tag, "pend_kind", int'(pend_kind), int'(k));
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_active = 1'b1;
        @(negedge clk); rx_active = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); arb_done = 1'b1;
        @(negedge clk); arb_done = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (dec_valid || frame_err)) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected output: actual valid=%0b err=%0b expected none",
                         dec_valid, frame_err);
            end else begin
                e = exp_q.pop_front();
                if (e.err) begin
                    if (!(frame_err && !dec_valid)) begin
                        fails++;
                        $display("FAIL %s error pulse: actual valid=%0b err=%0b expected err=1",
                                 e.tag, dec_valid, frame_err);
                    end
                end else if (!(dec_valid && !frame_err && dec_kind == e.kind &&
                               dec_speed == e.spd && dec_addr == e.addr &&
                               dec_data == e.data)) begin
                    fails++;
                    $display("FAIL %s decode: actual v=%0b e=%0b k=%0d s=%0d a=%0h d=%0h expected k=%0d s=%0d a=%0h d=%0h",
                             e.tag, dec_valid, frame_err, dec_kind, dec_speed, dec_addr,
                             dec_data, e.kind, e.spd, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and quiet idle line
        check(!dec_valid && !frame_err && !pend_valid, "R1", "outputs after reset",
              int'({dec_valid, frame_err, pend_valid}), 0);
        repeat (6) @(negedge clk);

        // R2 / R10: fair request at 200 Mbit/s loads pending
        bus_req(3'b011, 2'b01, -1, 1'b0, "R2");
        chk_pend(1'b1, 3'b011, "R10");
        check(pend_speed == 2'b01, "R10", "pend_speed", int'(pend_speed), 1);
        // R8: reception clears a pending fair request
        pulse_rx();
        chk_pend(1'b0, 3'b000, "R8");

        // R9: isochronous pending cleared by a read
        bus_req(3'b001, 2'b00, -1, 1'b0, "R2");
        chk_pend(1'b1, 3'b001, "R10");
        rd_req(4'h5, "R3");
        chk_pend(1'b0, 3'b000, "R9");

        // R8: isochronous survives reception; R10 replace by priority
        bus_req(3'b001, 2'b01, -1, 1'b0, "R2");
        pulse_rx();
        chk_pend(1'b1, 3'b001, "R8");
        bus_req(3'b010, 2'b00, -1, 1'b0, "R2");
        chk_pend(1'b1, 3'b010, "R10");
        pulse_done();
        chk_pend(1'b0, 3'b000, "R9");

        // R7: yielding requests overlapping reception are dropped
        bus_req(3'b011, 2'b00, 2, 1'b1, "R7");
        chk_pend(1'b0, 3'b000, "R7");
        bus_req(3'b010, 2'b01, 6, 1'b1, "R7");
        chk_pend(1'b0, 3'b000, "R7");
        bus_req(3'b000, 2'b01, 2, 1'b0, "R7");
        chk_pend(1'b1, 3'b000, "R7");
        pulse_done();
        chk_pend(1'b0, 3'b000, "R9");

        // R4 / R3
        wr_req(4'hA, 8'h5A, "R4");
        wr_req(4'h3, 8'hC1, "R4");
        rd_req(4'hF, "R3");

        // R5: bad stop bit, line held high, then recovery
        push_err("R5");
        drive(40'(7'b1000011) << 33, 7, -1);
        check(frame_err == 1'b1, "R5", "frame_err after bad stop", int'(frame_err), 1);
        drive(40'(2'b11) << 38, 2, -1);
        drive(40'd0, 1, -1);
        rd_req(4'h9, "R5");

        // R6: reserved kinds
        push_err("R6");
        drive(40'(7'b1110000) << 33, 7, -1);
        push_err("R6");
        drive(40'(7'b1111000) << 33, 7, -1);
        wr_req(4'h6, 8'h81, "R6");

        // R11: two frames with no idle between
        push_ok(3'b000, 2'b00, 4'd0, 8'd0, "R11");
        push_ok(3'b001, 2'b01, 4'd0, 8'd0, "R11");
        drive(40'(14'b1000000_1001010) << 26, 14, -1);
        chk_pend(1'b1, 3'b001, "R11");

        // R1: reset mid-frame abandons it and clears pending
        drive(40'(3'b110) << 37, 3, -1);
        @(negedge clk); rst = 1'b1; req_in = 1'b0;
        @(negedge clk); rst = 1'b0;
        check(!dec_valid && !frame_err && !pend_valid, "R1", "outputs after mid-frame reset",
              int'({dec_valid, frame_err, pend_valid}), 0);
        rd_req(4'h2, "R1");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R11", "expected items left", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule